// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block sits on a simple I/O access bus and implements the two-port method for reaching PCI configuration space. Software first loads a 32-bit selector into the address port window and then reads or writes through the data port window. The selector names a bus, a device slot and a register number. The data-port access then reaches that slot's local configuration storage.

Every slot has two separate byte arrays. The first is a 64-byte header. The second is an extended array that starts at register 0x40. A write that lands in the base-address-register area of the header raises a one-cycle strobe. That strobe carries the BAR offset and the complete aligned dword as it stands after the write. Illegal accesses raise a one-cycle error flag, and reads that fail return all ones. Slot 0 always holds a host bridge with fixed identification values at reset. A mask parameter says which of the other slots are populated.

Every response is registered. The read data, error flag and BAR strobe appear on the cycle after the access is presented.

Top module: `cfg_access_decoder`

## Requirements
- R1: After reset the selector register reads 0, and `rd_valid`, `acc_err` and `bar_upd` are all 0.
- R2: Ports 0x0CF8 to 0x0CFB reach the selector. The byte offset is port[1:0]. A 4-byte access is legal only at offset 0, a 2-byte access only at offsets 0 to 2, and a 1-byte access at any offset. `io_len` uses the codes 1, 2 and 4; any other value is illegal. An illegal access raises `acc_err`, and an illegal write leaves the selector unchanged. Legal writes update only the addressed bytes, taking them from the low lanes of `io_wdata`.
- R3: A legal selector read returns the bytes starting at the port offset, placed in the low lanes and zero-extended above the access length.
- R4: A data-window access (ports 0x0CFC to 0x0CFF) is legal only at port 0x0CFC exactly. Any other data port raises `acc_err`.
- R5: The selector fields are bus = bits 23:16, device = bits 15:11 and register = bits 7:0. A data access raises `acc_err` and writes nothing if the bus is not 0, if the device is NUM_SLOTS or higher, or if that slot is not populated.
- R6: The byte offset of a data access is register[1:0], and the same length/offset rules as R2 apply to it. Storage is little-endian. The result is placed in the low lanes and zero-extended.
- R7: Register numbers below 0x40 reach the header. Register numbers from 0x40 up to 0x40+EXT_BYTES-1 reach the extended array at index register-0x40, which is separate from the header. Any higher register number raises `acc_err`.
- R8: A legal data write with a register number from 0x10 to 0x26 inclusive pulses `bar_upd`. `bar_idx` = (register & ~3) - 0x10, and `bar_val` is the aligned dword after the write. A write at any other register number, including 0x27, leaves `bar_upd` low.
- R9: After reset, slot 0 reads vendor 0x8086 (bytes 0-1), device 0x1237 (bytes 2-3), revision 0x02 (byte 8), subclass 0x00 (byte 0x0A), class 0x06 (byte 0x0B) and header type 0x00 (byte 0x0E).
- R10: Each read in either window gives `rd_valid` exactly one cycle later. `acc_err` is a one-cycle pulse. A read that fails returns 0xFFFFFFFF.
- R11: An access to any port outside the two windows produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_len | input | 3 | Access length in bytes (1, 2, 4) |
| io_wdata | input | 32 | Write data, low lanes first |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| acc_err | output | 1 | Illegal access pulse |
| bar_upd | output | 1 | BAR write strobe |
| bar_idx | output | 5 | Byte offset of the BAR dword from 0x10 |
| bar_val | output | 32 | BAR dword after the write |

## Verification
The bound checker watches every cycle for the following. An illegal selector write must leave the selector unchanged. An off-offset data port must error. Every window read must be answered on the next cycle. Foreign ports must stay silent. Errors must never come with a BAR strobe. Failed reads must return all ones. BAR strobes must be aligned and follow a write.

Other behaviour can only be shown by the bench's scenarios. This covers the identification bytes of the host bridge, little-endian merging across partial writes, and the exact 0x26/0x27 edge of the strobe range. It also covers the separation of header and extended arrays, and the fact that refused writes to an absent slot or a wrong bus leave storage intact.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

    localparam logic [15:0] SEL_PORT_BASE = 16'h0CF8;
    localparam logic [15:0] DAT_PORT_BASE = 16'h0CFC;
    localparam int          HDR_BYTES     = 64;
    localparam logic [7:0]  BAR_FIRST     = 8'h10;
    localparam logic [7:0]  BAR_LAST      = 8'h26;

    typedef struct packed {
        logic        rd_valid;
        logic [31:0] rdata;
        logic        err;
        logic        bar;
        logic [4:0]  bar_idx;
        logic [31:0] bar_val;
    } cfgd_resp_t;

    // Length/offset legality shared by both windows.
    function automatic logic lane_ok(input logic [2:0] len, input logic [1:0] off);
        case (len)
            3'd4:    return off == 2'd0;
            3'd2:    return off != 2'd3;
            3'd1:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] len_be(input logic [2:0] len);
        case (len)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] be_to_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    // Reset image of the built-in host bridge header.
    function automatic logic [7:0] bridge_byte(input int idx);
        case (idx)
            0:       return 8'h86;
            1:       return 8'h80;
            2:       return 8'h37;
            3:       return 8'h12;
            8:       return 8'h02;
            11:      return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgd_sel_reg.sv
module cfgd_sel_reg (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] sel_q
);
    import cfgd_pkg::*;

    logic [31:0] mask;
    assign mask = be_to_mask(wr_be);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= (sel_q & ~mask) | (wr_data & mask);
    end
endmodule

// File: rtl/cfgd_slot_store.sv
module cfgd_slot_store #(
    parameter bit HOST_BRIDGE = 1'b0,
    parameter int EXT_BYTES   = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  reg_num,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_dword
);
    import cfgd_pkg::*;

    localparam int EXT_AW = $clog2(EXT_BYTES);

    logic [7:0] hdr [HDR_BYTES];
    logic [7:0] ext [EXT_BYTES];

    logic              in_hdr;
    logic [7:0]        ext_base;
    logic [EXT_AW-1:0] ext_idx [4];
    logic [5:0]        hdr_idx [4];

    assign in_hdr   = (reg_num[7:6] == 2'b00);
    assign ext_base = {reg_num[7:2], 2'b00} - 8'd64;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            e          = ext_base + 8'(i);
            ext_idx[i] = e[EXT_AW-1:0];
            hdr_idx[i] = {reg_num[5:2], 2'(i)};
            rd_dword[8*i +: 8] = in_hdr ? hdr[hdr_idx[i]] : ext[ext_idx[i]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < HDR_BYTES; k++)
                hdr[k] <= HOST_BRIDGE ? bridge_byte(k) : 8'h00;
            for (int k = 0; k < EXT_BYTES; k++)
                ext[k] <= 8'h00;
        end else if (wr_en) begin
            for (int i = 0; i < 4; i++) begin
                if (wr_be[i]) begin
                    if (in_hdr) hdr[hdr_idx[i]] <= wr_data[8*i +: 8];
                    else        ext[ext_idx[i]] <= wr_data[8*i +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder #(
    parameter int                   NUM_SLOTS = 4,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK = 4'b0011,
    parameter int                   EXT_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_valid,
    input  logic        io_write,
    input  logic [15:0] io_port,
    input  logic [2:0]  io_len,
    input  logic [31:0] io_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        acc_err,
    output logic        bar_upd,
    output logic [4:0]  bar_idx,
    output logic [31:0] bar_val
);
    import cfgd_pkg::*;

    localparam int REG_LIMIT = HDR_BYTES + EXT_BYTES;

    logic [31:0] addr_q;
    logic        hit_sel, hit_dat;
    logic [1:0]  port_off;
    logic [7:0]  reg_num;
    logic [4:0]  dev_num;
    logic [7:0]  bus_num;
    logic        present;
    logic        sel_ok, dat_ok, bar_hit;
    logic [3:0]  sel_be, dat_be;
    logic [31:0] sel_wdata, dat_wdata, dat_mask;
    logic [31:0] slot_dw [NUM_SLOTS];
    logic [31:0] cur_dw;
    logic [NUM_SLOTS-1:0] slot_wr;
    cfgd_resp_t  resp_d, resp_q;
    logic        unused_sel_bits;

    assign unused_sel_bits = ^{addr_q[31:24], addr_q[10:8]};

    assign hit_sel  = io_valid && (io_port[15:2] == SEL_PORT_BASE[15:2]);
    assign hit_dat  = io_valid && (io_port[15:2] == DAT_PORT_BASE[15:2]);
    assign port_off = io_port[1:0];
    assign reg_num  = addr_q[7:0];
    assign dev_num  = addr_q[15:11];
    assign bus_num  = addr_q[23:16];

    // Slot presence and per-slot read mux.
    always_comb begin
        present = 1'b0;
        cur_dw  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (dev_num == 5'(s)) begin
                present = SLOT_MASK[s];
                cur_dw  = slot_dw[s];
            end
        end
    end

    assign sel_ok = lane_ok(io_len, port_off);
    assign dat_ok = (port_off == 2'd0) && lane_ok(io_len, reg_num[1:0])
                 && (bus_num == 8'd0) && present && (int'(reg_num) < REG_LIMIT);

    assign sel_be    = len_be(io_len) << port_off;
    assign sel_wdata = io_wdata << {port_off, 3'b000};
    assign dat_be    = len_be(io_len) << reg_num[1:0];
    assign dat_wdata = io_wdata << {reg_num[1:0], 3'b000};
    assign dat_mask  = be_to_mask(dat_be);

    assign bar_hit = hit_dat && io_write && dat_ok
                  && (reg_num >= BAR_FIRST) && (reg_num <= BAR_LAST);

    cfgd_sel_reg u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hit_sel && io_write && sel_ok),
        .wr_be   (sel_be),
        .wr_data (sel_wdata),
        .sel_q   (addr_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_wr[s] = hit_dat && io_write && dat_ok && (dev_num == 5'(s));
        if (SLOT_MASK[s]) begin : g_on
            cfgd_slot_store #(
                .HOST_BRIDGE (s == 0),
                .EXT_BYTES   (EXT_BYTES)
            ) u_store (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (slot_wr[s]),
                .reg_num  (reg_num),
                .wr_be    (dat_be),
                .wr_data  (dat_wdata),
                .rd_dword (slot_dw[s])
            );
        end else begin : g_off
            assign slot_dw[s] = '0;
        end
    end

    always_comb begin
        resp_d          = '0;
        resp_d.rd_valid = (hit_sel || hit_dat) && !io_write;
        if (hit_sel)      resp_d.err = !sel_ok;
        else if (hit_dat) resp_d.err = !dat_ok;
        if (resp_d.rd_valid) begin
            if (resp_d.err)
                resp_d.rdata = '1;
            else if (hit_sel)
                resp_d.rdata = (addr_q >> {port_off, 3'b000}) & be_to_mask(len_be(io_len));
            else
                resp_d.rdata = (cur_dw >> {reg_num[1:0], 3'b000}) & be_to_mask(len_be(io_len));
        end
        resp_d.bar     = bar_hit;
        resp_d.bar_idx = bar_hit ? 5'({reg_num[7:2], 2'b00} - BAR_FIRST) : 5'd0;
        resp_d.bar_val = bar_hit ? ((cur_dw & ~dat_mask) | (dat_wdata & dat_mask)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign rd_valid = resp_q.rd_valid;
    assign rd_data  = resp_q.rdata;
    assign acc_err  = resp_q.err;
    assign bar_upd  = resp_q.bar;
    assign bar_idx  = resp_q.bar_idx;
    assign bar_val  = resp_q.bar_val;
endmodule

// File: rtl/cfgd_checker.sv
module cfgd_checker (
    input logic        clk,
    input logic        rst,
    input logic        io_valid,
    input logic        io_write,
    input logic [15:0] io_port,
    input logic [2:0]  io_len,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        acc_err,
    input logic        bar_upd,
    input logic [4:0]  bar_idx,
    input logic [31:0] addr_q
);
    logic in_sel, in_dat, legal_len;

    assign in_sel = io_valid && (io_port[15:2] == 14'h033E);
    assign in_dat = io_valid && (io_port[15:2] == 14'h033F);
    assign legal_len = (io_len == 3'd1)
                    || (io_len == 3'd2 && io_port[1:0] != 2'd3)
                    || (io_len == 3'd4 && io_port[1:0] == 2'd0);

    AST_SEL_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        in_sel && io_write && !legal_len |=> $stable(addr_q)); // R2

    AST_DATA_OFFSET_ERR: assert property (@(posedge clk) disable iff (rst)
        in_dat && io_port[1:0] != 2'd0 |=> acc_err); // R4

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> !bar_upd); // R5

    AST_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        bar_upd |-> (bar_idx[1:0] == 2'd0) && (bar_idx <= 5'd20)); // R8

    AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        bar_upd |-> $past(io_valid && io_write)); // R8

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (in_sel || in_dat) && !io_write |=> rd_valid); // R10

    AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        rd_valid && acc_err |-> rd_data == 32'hFFFF_FFFF); // R10

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
        io_valid && !in_sel && !in_dat |=> !rd_valid && !acc_err && !bar_upd); // R11
endmodule

bind cfg_access_decoder cfgd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_valid (io_valid),
    .io_write (io_write),
    .io_port  (io_port),
    .io_len   (io_len),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .acc_err  (acc_err),
    .bar_upd  (bar_upd),
    .bar_idx  (bar_idx),
    .addr_q   (addr_q)
);

// File: tb/cfg_access_decoder_tb_top.sv
module cfg_access_decoder_tb_top;

    localparam logic [15:0] SP = 16'h0CF8;
    localparam logic [15:0] DP = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_port = '0;
    logic [2:0]  io_len = '0;
    logic [31:0] io_wdata = '0;
    logic        rd_valid, acc_err, bar_upd;
    logic [31:0] rd_data, bar_val;
    logic [4:0]  bar_idx;

    always #5 clk = ~clk;

    cfg_access_decoder dut_i (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_port(io_port), .io_len(io_len), .io_wdata(io_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .bar_upd(bar_upd), .bar_idx(bar_idx), .bar_val(bar_val)
    );

    typedef struct {
        bit        rdv;
        bit [31:0] rd;
        bit        err;
        bit        bar;
        bit [4:0]  idx;
        bit [31:0] val;
        string     tag;
        int        stamp;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   edge_cnt = 0;
    bit   mon_en = 0;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic acc(bit w, logic [15:0] port, logic [2:0] len, logic [31:0] d,
                       bit erdv, logic [31:0] erd, bit eerr, bit ebar,
                       logic [4:0] eidx, logic [31:0] eval, string tag);
        exp_t e;
        @(negedge clk);
        io_valid = 1'b1; io_write = w; io_port = port; io_len = len; io_wdata = d;
        e.rdv = erdv; e.rd = erd; e.err = eerr; e.bar = ebar;
        e.idx = eidx; e.val = eval; e.tag = tag; e.stamp = edge_cnt + 1;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            io_valid = 1'b0; io_write = 1'b0;
        end
    endtask

    task automatic rd_ok(logic [15:0] p, logic [2:0] l, logic [31:0] v, string t);
        acc(0, p, l, 0, 1, v, 0, 0, 0, 0, t);
    endtask
    task automatic rd_bad(logic [15:0] p, logic [2:0] l, string t);
        acc(0, p, l, 0, 1, 32'hFFFF_FFFF, 1, 0, 0, 0, t);
    endtask
    task automatic wr_ok(logic [15:0] p, logic [2:0] l, logic [31:0] d, string t);
        acc(1, p, l, d, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic wr_bad(logic [15:0] p, logic [2:0] l, logic [31:0] d, string t);
        acc(1, p, l, d, 0, 0, 1, 0, 0, 0, t);
    endtask
    task automatic wr_bar(logic [15:0] p, logic [2:0] l, logic [31:0] d,
                          logic [4:0] i, logic [31:0] v, string t);
        acc(1, p, l, d, 0, 0, 0, 1, i, v, t);
    endtask
    task automatic set_sel(logic [31:0] v);
        wr_ok(SP, 4, v, "R2 selector load");
    endtask

    // Monitor: samples 2 ns after each rising edge and pops the scoreboard.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            edge_cnt++;
            if (mon_en) begin
                if (exp_q.size() > 0 && exp_q[0].stamp == edge_cnt) begin
                    e = exp_q.pop_front();
                end else begin
                    e.rdv = 0; e.rd = 0; e.err = 0; e.bar = 0; e.idx = 0; e.val = 0;
                    e.tag = "R10 idle"; e.stamp = edge_cnt;
                end
                check(rd_valid == e.rdv, e.tag, "rd_valid", 32'(rd_valid), 32'(e.rdv));
                if (e.rdv) check(rd_data == e.rd, e.tag, "rd_data", rd_data, e.rd);
                check(acc_err == e.err, e.tag, "acc_err", 32'(acc_err), 32'(e.err));
                check(bar_upd == e.bar, e.tag, "bar_upd", 32'(bar_upd), 32'(e.bar));
                if (e.bar) begin
                    check(bar_idx == e.idx, e.tag, "bar_idx", 32'(bar_idx), 32'(e.idx));
                    check(bar_val == e.val, e.tag, "bar_val", bar_val, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rd_valid && !acc_err && !bar_upd, "R1", "outputs in reset",
              {29'd0, rd_valid, acc_err, bar_upd}, 32'd0);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1 and R9: reset values
        rd_ok(SP, 4, 32'h0, "R1 selector reset");
        rd_ok(DP, 4, 32'h1237_8086, "R9 vendor/device");
        set_sel(32'h8000_0008);
        rd_ok(DP, 4, 32'h0600_0002, "R9 revision/class");
        rd_ok(DP, 1, 32'h02, "R9 revision byte");
        set_sel(32'h8000_000B);
        rd_ok(DP, 1, 32'h06, "R9 class byte");
        set_sel(32'h8000_000E);
        rd_ok(DP, 1, 32'h00, "R9 header type");
        set_sel(32'h8000_000A);
        rd_ok(DP, 2, 32'h0600, "R6 two-byte at offset 2");

        // R4: data window offsets
        rd_bad(16'h0CFD, 4, "R4 port CFD");
        rd_bad(16'h0CFE, 1, "R4 port CFE");
        wr_bad(16'h0CFF, 1, 32'h11, "R4 port CFF write");

        // R2/R3: selector byte lanes
        set_sel(32'h0);
        wr_ok(16'h0CFB, 1, 32'h80, "R2 byte write off3");
        wr_ok(16'h0CF9, 2, 32'h1234, "R2 half write off1");
        rd_ok(SP, 4, 32'h8012_3400, "R2 merged selector");
        rd_ok(16'h0CF9, 2, 32'h1234, "R3 half read off1");
        rd_ok(16'h0CFA, 1, 32'h12, "R3 byte read off2");
        rd_ok(16'h0CFB, 1, 32'h80, "R3 byte read off3");
        rd_bad(16'h0CFB, 2, "R2 half read off3");
        wr_bad(16'h0CFB, 2, 32'hFFFF, "R2 half write off3");
        wr_bad(16'h0CF9, 4, 32'hFFFF_FFFF, "R2 word write off1");
        wr_bad(SP, 3, 32'hFFFF_FFFF, "R2 bad length");
        rd_ok(SP, 4, 32'h8012_3400, "R2 selector unchanged");

        // R5: target selection
        rd_bad(DP, 4, "R5 bus nonzero read");
        set_sel(32'h8001_0000);
        wr_bad(DP, 4, 32'hFFFF_FFFF, "R5 bus nonzero write");
        set_sel(32'h8000_0000);
        rd_ok(DP, 4, 32'h1237_8086, "R5 refused write left slot 0");
        set_sel(32'h8000_1000);
        rd_bad(DP, 4, "R5 absent slot read");
        wr_bad(DP, 4, 32'h1, "R5 absent slot write");
        set_sel(32'h8000_2800);
        rd_bad(DP, 4, "R5 slot beyond count");

        // R6/R8: slot 1 header and BAR strobe
        set_sel(32'h8000_0810);
        wr_bar(DP, 4, 32'hDEAD_BEEF, 5'd0, 32'hDEAD_BEEF, "R8 full BAR0 write");
        rd_ok(DP, 4, 32'hDEAD_BEEF, "R6 readback");
        set_sel(32'h8000_0812);
        wr_bar(DP, 2, 32'h5566, 5'd0, 32'h5566_BEEF, "R8 partial merge");
        set_sel(32'h8000_0811);
        rd_ok(DP, 1, 32'hBE, "R6 byte offset 1");
        set_sel(32'h8000_0813);
        rd_bad(DP, 2, "R6 half at offset 3");
        set_sel(32'h8000_0815);
        wr_bar(DP, 1, 32'h5A, 5'd4, 32'h0000_5A00, "R8 byte in BAR1");
        set_sel(32'h8000_0826);
        wr_bar(DP, 2, 32'h7788, 5'd20, 32'h7788_0000, "R8 last strobe register");
        set_sel(32'h8000_0827);
        wr_ok(DP, 1, 32'h99, "R8 0x27 no strobe");
        set_sel(32'h8000_0824);
        rd_ok(DP, 4, 32'h9988_0000, "R8 0x27 stored");
        set_sel(32'h8000_0828);
        wr_ok(DP, 4, 32'h1, "R8 0x28 no strobe");
        set_sel(32'h8000_080C);
        wr_ok(DP, 4, 32'hAABB_CCDD, "R8 0x0C no strobe");

        // R7: extended region
        set_sel(32'h8000_0840);
        wr_ok(DP, 4, 32'h0102_0304, "R7 ext write");
        rd_ok(DP, 4, 32'h0102_0304, "R7 ext readback");
        set_sel(32'h8000_0800);
        rd_ok(DP, 4, 32'h0, "R7 header untouched");
        set_sel(32'h8000_087C);
        wr_ok(DP, 4, 32'hCAFE_F00D, "R7 ext last dword");
        rd_ok(DP, 4, 32'hCAFE_F00D, "R7 ext last readback");
        set_sel(32'h8000_0880);
        rd_bad(DP, 4, "R7 beyond ext read");
        wr_bad(DP, 4, 32'h5, "R7 beyond ext write");
        set_sel(32'h8000_0040);
        rd_ok(DP, 4, 32'h0, "R7 slot 0 ext separate");

        // R11: foreign ports
        acc(1, 16'h0080, 4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R11 foreign write");
        acc(0, 16'h0CF7, 4, 0, 0, 0, 0, 0, 0, 0, "R11 foreign read");
        acc(1, 16'h0D00, 4, 32'h0, 0, 0, 0, 0, 0, 0, "R11 foreign write 2");
        rd_ok(SP, 4, 32'h8000_0040, "R11 selector unchanged");

        idle(4);
        check(exp_q.size() == 0, "R10", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule